// File: doc/BRIEF.md
# Strided Source/Destination Address Sequencer

This block generates the word addresses for one DMA channel. A start pulse captures a descriptor: source and destination start addresses, a length word, a stride word and mode flags. The block then presents one source and one destination address per beat. Each time the consumer accepts a beat with `advance`, the block moves to the next beat. A flag marks the final beat, and a one-cycle pulse reports completion.

There are two modes. In linear mode the length word is a plain byte count. In two-dimensional mode the length word holds a row byte length and a row count. At the end of each row, a signed byte stride is added to each side's address, with a separate stride for source and for destination. Each side can hold its address fixed or step it by the beat size. The `LITE` parameter builds a reduced channel that has no two-dimensional mode and only a 16-bit byte count.

Top module: `dma_addr_seq`

## Requirements
- R1: After reset `busy`, `last_beat` and `done` are 0.
- R2: When `start` is high while idle, `src_addr` and `dst_addr` show the captured start addresses in the next cycle, and `busy` is 1.
- R3: The beat size is 16 bytes when `cfg_wide`=1 and 4 bytes when it is 0. On each accepted beat, a side whose increment flag is 1 steps its address by the beat size. A side whose increment flag is 0 does not step.
- R4: In linear mode (`cfg_2d`=0) all 32 bits of `cfg_len` form a byte count. The transfer runs ceil(len/beat) beats, with a minimum of one beat, so a length of 0 gives one beat.
- R5: In two-dimensional mode, `cfg_len[15:0]` is the row byte length and `cfg_len[29:16]` is the number of rows minus one. `cfg_len[31:30]` are ignored. Each row runs ceil(row/beat) beats, with a minimum of one.
- R6: `cfg_stride[15:0]` is the source stride and `cfg_stride[31:16]` is the destination stride. Both are signed two's-complement byte values. When the last beat of a row is accepted, each side's stride is added on top of that side's normal step. This applies whatever the increment flag is.
- R7: `last_beat` is 1 exactly while `busy` is 1 and the current beat is the final beat of the final row.
- R8: `done` is a one-cycle pulse in the cycle after the final beat is accepted, and `busy` is 0 in that cycle.
- R9: While `advance` is 0, the addresses and the beat position hold.
- R10: A `start` while `busy` is 1 is ignored, and the running transfer continues unchanged.
- R11: With `LITE`=1, `cfg_2d` is ignored and only `cfg_len[15:0]` counts as the byte length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Capture the descriptor and begin (honoured when idle) |
| advance | input | 1 | Current beat accepted |
| cfg_src_addr | input | 32 | Source start byte address |
| cfg_dst_addr | input | 32 | Destination start byte address |
| cfg_len | input | 32 | Length word |
| cfg_stride | input | 32 | Stride word: destination [31:16], source [15:0] |
| cfg_2d | input | 1 | Two-dimensional mode |
| cfg_wide | input | 1 | 16-byte beats instead of 4-byte beats |
| cfg_src_inc | input | 1 | Step the source address per beat |
| cfg_dst_inc | input | 1 | Step the destination address per beat |
| src_addr | output | 32 | Current source address |
| dst_addr | output | 32 | Current destination address |
| busy | output | 1 | A transfer is in progress |
| last_beat | output | 1 | The current beat is the final one |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that `advance` only matters while `busy` is 1, and that the configuration inputs matter only in the cycle `start` is accepted. They do not assume the consumer accepts every beat. The stimulus changes the descriptor inputs only around start pulses. It throttles `advance` randomly, at rates from 30 to 100 percent, so that hold cycles appear in the middle of rows and at row ends. It also issues one start pulse during a running transfer. A reduced instance runs alongside the full one on the same inputs, so every descriptor also exercises the lite length rule.

// File: rtl/dma_addr_pkg.sv
package dma_addr_pkg;

    localparam int unsigned ADDR_W     = 32;
    localparam int unsigned LEN_W      = 32;
    localparam int unsigned ROWLEN_W   = 16;
    localparam int unsigned ROWCNT_W   = 14;
    localparam int unsigned STRIDE_W   = 16;
    localparam int unsigned ROWCNT_LSB = ROWLEN_W;
    localparam int unsigned NARROW_B   = 4;
    localparam int unsigned WIDE_B     = 16;
    localparam int unsigned NUM_SIDES  = 2;

    typedef struct packed {
        logic                busy;
        logic                done;
        logic                wide;
        logic [ROWLEN_W-1:0] row_len;
        logic [LEN_W-1:0]    rem;
        logic [ROWCNT_W-1:0] rows;
    } ctrl_t;

    typedef struct packed {
        logic [ADDR_W-1:0]   addr;
        logic                inc;
        logic                wide;
        logic [STRIDE_W-1:0] stride;
    } side_t;

    function automatic logic [LEN_W-1:0] beat_bytes(input logic wide);
        return wide ? LEN_W'(WIDE_B) : LEN_W'(NARROW_B);
    endfunction

endpackage

// File: rtl/dma_beat_ctrl.sv
module dma_beat_ctrl
    import dma_addr_pkg::*;
#(
    parameter bit LITE = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             advance,
    input  logic             mode_2d,
    input  logic             wide,
    input  logic [LEN_W-1:0] len,
    output logic             load,
    output logic             step,
    output logic             row_end,
    output logic             busy,
    output logic             last,
    output logic             done
);

    ctrl_t q, d;
    logic  use_2d;
    logic [LEN_W-1:0] eff_len;
    logic [LEN_W-1:0] bsz;

    always_comb begin
        use_2d  = mode_2d && !LITE;
        eff_len = LITE ? LEN_W'(len[ROWLEN_W-1:0]) : len;
        bsz     = beat_bytes(q.wide);
        load    = start && !q.busy;
        step    = q.busy && advance;
        row_end = (q.rem <= bsz);
        last    = q.busy && row_end && (q.rows == '0);

        d      = q;
        d.done = 1'b0;
        if (load) begin
            d.busy = 1'b1;
            d.wide = wide;
            if (use_2d) begin
                d.row_len = len[ROWLEN_W-1:0];
                d.rem     = LEN_W'(len[ROWLEN_W-1:0]);
                d.rows    = len[ROWCNT_LSB +: ROWCNT_W];
            end else begin
                d.row_len = '0;
                d.rem     = eff_len;
                d.rows    = '0;
            end
        end else if (step) begin
            if (row_end) begin
                if (q.rows == '0) begin
                    d.busy = 1'b0;
                    d.done = 1'b1;
                end else begin
                    d.rows = q.rows - 1'b1;
                    d.rem  = LEN_W'(q.row_len);
                end
            end else begin
                d.rem = q.rem - bsz;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy = q.busy;
    assign done = q.done;

endmodule

// File: rtl/dma_addr_side.sv
module dma_addr_side
    import dma_addr_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [ADDR_W-1:0]   start_addr,
    input  logic                inc,
    input  logic                wide,
    input  logic [STRIDE_W-1:0] stride,
    input  logic                step,
    input  logic                row_end,
    output logic [ADDR_W-1:0]   addr
);

    localparam int unsigned EXT_W = ADDR_W - STRIDE_W;

    side_t q, d;
    logic [ADDR_W-1:0] inc_amt;
    logic [ADDR_W-1:0] jump;

    always_comb begin
        inc_amt = q.inc ? (q.wide ? ADDR_W'(WIDE_B) : ADDR_W'(NARROW_B)) : '0;
        jump    = row_end ? {{EXT_W{q.stride[STRIDE_W-1]}}, q.stride} : '0;
        d = q;
        if (load) begin
            d.addr   = start_addr;
            d.inc    = inc;
            d.wide   = wide;
            d.stride = stride;
        end else if (step) begin
            d.addr = q.addr + inc_amt + jump;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign addr = q.addr;

endmodule

// File: rtl/dma_addr_seq.sv
module dma_addr_seq
    import dma_addr_pkg::*;
#(
    parameter bit LITE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              advance,
    input  logic [ADDR_W-1:0] cfg_src_addr,
    input  logic [ADDR_W-1:0] cfg_dst_addr,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [31:0]       cfg_stride,
    input  logic              cfg_2d,
    input  logic              cfg_wide,
    input  logic              cfg_src_inc,
    input  logic              cfg_dst_inc,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr,
    output logic              busy,
    output logic              last_beat,
    output logic              done
);

    logic load, step, row_end;
    logic [ADDR_W-1:0]   side_start  [NUM_SIDES];
    logic                side_inc    [NUM_SIDES];
    logic [STRIDE_W-1:0] side_stride [NUM_SIDES];
    logic [ADDR_W-1:0]   side_addr   [NUM_SIDES];

    assign side_start[0]  = cfg_src_addr;
    assign side_start[1]  = cfg_dst_addr;
    assign side_inc[0]    = cfg_src_inc;
    assign side_inc[1]    = cfg_dst_inc;
    assign side_stride[0] = cfg_stride[STRIDE_W-1:0];
    assign side_stride[1] = cfg_stride[2*STRIDE_W-1:STRIDE_W];

    dma_beat_ctrl #(.LITE(LITE)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .advance (advance),
        .mode_2d (cfg_2d),
        .wide    (cfg_wide),
        .len     (cfg_len),
        .load    (load),
        .step    (step),
        .row_end (row_end),
        .busy    (busy),
        .last    (last_beat),
        .done    (done)
    );

    for (genvar g = 0; g < NUM_SIDES; g++) begin : g_side
        dma_addr_side u_side (
            .clk        (clk),
            .rst_n      (rst_n),
            .load       (load),
            .start_addr (side_start[g]),
            .inc        (side_inc[g]),
            .wide       (cfg_wide),
            .stride     (side_stride[g]),
            .step       (step),
            .row_end    (row_end),
            .addr       (side_addr[g])
        );
    end

    assign src_addr = side_addr[0];
    assign dst_addr = side_addr[1];

endmodule

// File: rtl/dma_addr_seq_chk.sv
module dma_addr_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        advance,
    input logic [31:0] cfg_src_addr,
    input logic [31:0] cfg_dst_addr,
    input logic [31:0] src_addr,
    input logic [31:0] dst_addr,
    input logic        busy,
    input logic        last_beat,
    input logic        done
);

    a_r2_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy |=> busy && src_addr == $past(cfg_src_addr)
                               && dst_addr == $past(cfg_dst_addr));

    a_r7_last_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        last_beat |-> busy);

    a_r8_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        last_beat && advance |=> done && !busy);

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !advance |=> busy && $stable(src_addr) && $stable(dst_addr)
                             && $stable(last_beat));

    a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start && !advance |=> $stable(src_addr) && $stable(dst_addr));

endmodule

bind dma_addr_seq dma_addr_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .advance      (advance),
    .cfg_src_addr (cfg_src_addr),
    .cfg_dst_addr (cfg_dst_addr),
    .src_addr     (src_addr),
    .dst_addr     (dst_addr),
    .busy         (busy),
    .last_beat    (last_beat),
    .done         (done)
);

// File: tb/dma_addr_seq_test.sv
`timescale 1ns/1ps
module dma_addr_seq_test;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, start, advance;
    logic [31:0] cfg_src_addr, cfg_dst_addr, cfg_len, cfg_stride;
    logic cfg_2d, cfg_wide, cfg_src_inc, cfg_dst_inc;

    logic [31:0] o_src [2];
    logic [31:0] o_dst [2];
    logic o_busy [2];
    logic o_last [2];
    logic o_done [2];

    int checks = 0;
    int failures = 0;

    dma_addr_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start), .advance(advance),
        .cfg_src_addr(cfg_src_addr), .cfg_dst_addr(cfg_dst_addr),
        .cfg_len(cfg_len), .cfg_stride(cfg_stride), .cfg_2d(cfg_2d),
        .cfg_wide(cfg_wide), .cfg_src_inc(cfg_src_inc), .cfg_dst_inc(cfg_dst_inc),
        .src_addr(o_src[0]), .dst_addr(o_dst[0]), .busy(o_busy[0]),
        .last_beat(o_last[0]), .done(o_done[0]));

    dma_addr_seq #(.LITE(1'b1)) uut_lite (
        .clk(clk), .rst_n(rst_n), .start(start), .advance(advance),
        .cfg_src_addr(cfg_src_addr), .cfg_dst_addr(cfg_dst_addr),
        .cfg_len(cfg_len), .cfg_stride(cfg_stride), .cfg_2d(cfg_2d),
        .cfg_wide(cfg_wide), .cfg_src_inc(cfg_src_inc), .cfg_dst_inc(cfg_dst_inc),
        .src_addr(o_src[1]), .dst_addr(o_dst[1]), .busy(o_busy[1]),
        .last_beat(o_last[1]), .done(o_done[1]));

    // reference model state, one slot per instance (1 = lite)
    logic        m_busy [2];
    logic        m_done [2];
    logic        m_wide [2];
    logic        m_si   [2];
    logic        m_di   [2];
    logic [31:0] m_src  [2];
    logic [31:0] m_dst  [2];
    logic [31:0] m_rem  [2];
    logic [31:0] m_row  [2];
    logic [13:0] m_rows [2];
    logic [15:0] m_ss   [2];
    logic [15:0] m_ds   [2];

    function automatic logic [31:0] bsz(input logic w);
        return w ? 32'd16 : 32'd4;
    endfunction

    function automatic logic [31:0] sext(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    function automatic logic exp_last(input int i);
        return m_busy[i] && (m_rem[i] <= bsz(m_wide[i])) && (m_rows[i] == 14'd0);
    endfunction

    task automatic chk(input string tag, input string what, input int i,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s inst%0d actual=%h expected=%h", tag, what, i, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        for (int i = 0; i < 2; i++) begin
            chk(tag, "busy", i, 32'(o_busy[i]), 32'(m_busy[i]));
            chk("R7", "last_beat", i, 32'(o_last[i]), 32'(exp_last(i)));
            chk("R8", "done", i, 32'(o_done[i]), 32'(m_done[i]));
            if (m_busy[i]) begin
                chk(tag, "src_addr", i, o_src[i], m_src[i]);
                chk(tag, "dst_addr", i, o_dst[i], m_dst[i]);
            end
        end
    endtask

    // advance model by one clock with the inputs now driven, then compare
    task automatic tick(input string tag);
        for (int i = 0; i < 2; i++) begin
            logic [31:0] b;
            logic re;
            b = bsz(m_wide[i]);
            re = m_rem[i] <= b;
            m_done[i] = 1'b0;
            if (m_busy[i] && advance) begin
                m_src[i] = m_src[i] + (m_si[i] ? b : 32'd0) + (re ? sext(m_ss[i]) : 32'd0);
                m_dst[i] = m_dst[i] + (m_di[i] ? b : 32'd0) + (re ? sext(m_ds[i]) : 32'd0);
                if (re) begin
                    if (m_rows[i] == 14'd0) begin
                        m_busy[i] = 1'b0;
                        m_done[i] = 1'b1;
                    end else begin
                        m_rows[i] = m_rows[i] - 14'd1;
                        m_rem[i]  = m_row[i];
                    end
                end else begin
                    m_rem[i] = m_rem[i] - b;
                end
            end else if (start && !m_busy[i]) begin
                m_busy[i] = 1'b1;
                m_wide[i] = cfg_wide;
                m_si[i]   = cfg_src_inc;
                m_di[i]   = cfg_dst_inc;
                m_src[i]  = cfg_src_addr;
                m_dst[i]  = cfg_dst_addr;
                m_ss[i]   = cfg_stride[15:0];
                m_ds[i]   = cfg_stride[31:16];
                if (cfg_2d && i == 0) begin
                    m_row[i]  = {16'd0, cfg_len[15:0]};
                    m_rem[i]  = {16'd0, cfg_len[15:0]};
                    m_rows[i] = cfg_len[29:16];
                end else begin
                    m_rem[i]  = (i == 1) ? {16'd0, cfg_len[15:0]} : cfg_len;
                    m_rows[i] = 14'd0;
                end
            end
        end
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic run_xfer(input string tag, input logic [31:0] s, input logic [31:0] d,
                            input logic [31:0] len, input logic [31:0] str,
                            input logic two_d, input logic wide, input logic si,
                            input logic di, input int pct, input bit mid);
        int n;
        cfg_src_addr = s; cfg_dst_addr = d; cfg_len = len; cfg_stride = str;
        cfg_2d = two_d; cfg_wide = wide; cfg_src_inc = si; cfg_dst_inc = di;
        start = 1'b1; advance = 1'b0;
        tick(tag);
        start = 1'b0;
        n = 0;
        while ((m_busy[0] || m_busy[1]) && n < 30000) begin
            advance = (($urandom % 100) < pct);
            if (mid && n == 2) begin
                start = 1'b1;
                cfg_src_addr = 32'hDEAD_0000;
                cfg_len = 32'd8;
            end
            tick(tag);
            start = 1'b0;
            n++;
        end
        advance = 1'b0;
        tick(tag);
        tick(tag);
    endtask

    initial begin
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 2; i++) begin
            m_busy[i] = 0; m_done[i] = 0; m_wide[i] = 0; m_si[i] = 0; m_di[i] = 0;
            m_src[i] = 0; m_dst[i] = 0; m_rem[i] = 0; m_row[i] = 0; m_rows[i] = 0;
            m_ss[i] = 0; m_ds[i] = 0;
        end
        rst_n = 1'b0; start = 1'b0; advance = 1'b0;
        cfg_src_addr = '0; cfg_dst_addr = '0; cfg_len = '0; cfg_stride = '0;
        cfg_2d = 0; cfg_wide = 0; cfg_src_inc = 0; cfg_dst_inc = 0;
        @(negedge clk); @(negedge clk);
        // R1: reset state
        compare("R1");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1");

        // R2 / R3 narrow, both sides stepping
        run_xfer("R2", 32'h1000_0000, 32'h2000_0000, 32'd32, 32'd0, 0, 0, 1, 1, 100, 0);
        // R3 wide beats, destination fixed
        run_xfer("R3", 32'h0000_4000, 32'h7E20_0004, 32'd64, 32'd0, 0, 1, 1, 0, 100, 0);
        // R4 zero length gives one beat; 5 bytes gives two
        run_xfer("R4", 32'h100, 32'h200, 32'd0, 32'd0, 0, 0, 1, 1, 100, 0);
        run_xfer("R4", 32'h100, 32'h200, 32'd5, 32'd0, 0, 0, 1, 1, 100, 0);
        // R5 three rows of 12 bytes, top bits set and ignored
        run_xfer("R5", 32'h8000, 32'h9000, {2'b11, 14'd2, 16'd12}, 32'h0010_0020, 1, 0, 1, 1, 100, 0);
        // R6 negative destination stride, positive source stride, fixed source
        run_xfer("R6", 32'h8000, 32'h9000, {2'b00, 14'd3, 16'd8}, 32'hFFF0_0008, 1, 0, 0, 1, 100, 0);
        run_xfer("R6", 32'h0, 32'h40, {2'b00, 14'd1, 16'd32}, 32'h8000_7FFF, 1, 1, 1, 1, 80, 0);
        // R9 heavy throttling
        run_xfer("R9", 32'h3000, 32'h5000, {2'b00, 14'd2, 16'd20}, 32'h0004_FFFC, 1, 0, 1, 1, 30, 0);
        // R10 start during a transfer
        run_xfer("R10", 32'hA000, 32'hB000, 32'd64, 32'd0, 0, 0, 1, 1, 100, 1);
        // R11 lite: 2D flag and high length bits ignored
        run_xfer("R11", 32'h100, 32'h900, 32'h0001_0010, 32'h0000_0000, 1, 0, 1, 1, 100, 0);
        run_xfer("R11", 32'h100, 32'h900, 32'h0001_0010, 32'h0000_0000, 0, 1, 1, 1, 100, 0);

        // constrained random mix
        for (int k = 0; k < 40; k++) begin
            logic td;
            logic [31:0] len;
            td = $urandom % 2;
            if (td) len = {2'($urandom), 14'($urandom % 4), 16'($urandom % 48)};
            else    len = 32'($urandom % 160);
            run_xfer(td ? "R5" : "R4", $urandom, $urandom, len,
                     {16'($urandom % 64) - 16'd32, 16'($urandom % 64) - 16'd32},
                     td, 1'($urandom), 1'($urandom), 1'($urandom),
                     40 + ($urandom % 61), 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule